// File: doc/BRIEF.md
# PCI Host Configuration Access Controller

This block lets a processor on a 32-bit big-endian local register bus reach the configuration space of devices on a PCI bus. Software first writes a target descriptor into the address port. That descriptor holds an enable flag, a bus number, a device number, a function number and a register word index. Software then reads or writes the data port. Each data-port access starts one configuration read or write on the PCI master side. The local acknowledge is held back until that transaction finishes.

A third register holds the bridge's own primary bus number. When the target bus matches it, the request goes out as type 0, and the device number is turned into a single IDSEL line in the upper address bits. For any other bus, the request goes out as type 1 and the routing fields are packed into the address. Words crossing the address and data ports are byte-reversed, so that byte addresses agree between the big-endian local image and the little-endian PCI word.

The PCI master is modelled as a request/response handshake: `pm_req` is held until `pm_done` arrives, with an abort flag beside it.

Top module: `pci_cfg_host`

## Requirements
- R1: After reset, reads of the address port and of the bus number register return zero.
- R2: The address port stores the byte-reversed local write word masked to its writable bits. In the PCI word these are: register index at 5:0, device at 12:8, function at 15:13, bus at 23:16, enable at 24. All other bits read as zero. A read returns the stored word byte-reversed.
- R3: The bus number register takes local write bits 7:0. A read returns them with bits 31:8 zero.
- R4: An access whose byte enables are not all four set (`lb_be` other than 4'hF), or that selects code 3, is acknowledged one cycle later with `lb_err` high. It changes no register and makes no PCI request. Select codes are: 0 address port, 1 data port, 2 bus number.
- R5: With enable set and target bus equal to the primary bus, a data-port access makes a type 0 request (`pm_type1` low). Its address has bit (IDSEL_BASE + device) set when that position is below 32, the function at 10:8, the register index at 7:2, and 1:0 = 00.
- R6: With enable set and a different target bus, the request is type 1, with address {8'h00, bus, device[4:0], function[2:0], register[5:0], 2'b01}.
- R7: Write data leaves on `pm_wdata` byte-reversed. Read data from `pm_rdata` returns to `lb_rdata` byte-reversed.
- R8: With enable clear, a data-port access raises no `pm_req` and is acknowledged one cycle later. A read then returns 32'hFFFFFFFF.
- R9: A PCI-bound access is acknowledged in the cycle after the edge that samples `pm_done`. At most one request is outstanding, and strobes arriving while a request is open are ignored.
- R10: A completion with `pm_abort` set returns 32'hFFFFFFFF for a read. For a write it completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_stb | input | 1 | One-cycle local access strobe |
| lb_we | input | 1 | 1 = write, 0 = read |
| lb_sel | input | 2 | Register select |
| lb_be | input | 4 | Byte enables |
| lb_wdata | input | 32 | Local write word |
| lb_rdata | output | 32 | Local read word, valid with lb_ack |
| lb_ack | output | 1 | One-cycle access completion |
| lb_err | output | 1 | Access rejected |
| pm_req | output | 1 | Configuration request held until pm_done |
| pm_write | output | 1 | Request is a configuration write |
| pm_type1 | output | 1 | Request is type 1 |
| pm_addr | output | 32 | Formatted configuration address |
| pm_wdata | output | 32 | Little-endian write word |
| pm_done | input | 1 | Completion of the open request |
| pm_abort | input | 1 | Completion ended in master abort |
| pm_rdata | input | 32 | Little-endian read word |

## Verification
The bench builds the block with IDSEL_BASE at its default of 16, so IDSEL lines exist for devices 0 to 15. This brings the case of device 20 within reach, where a type 0 address carries no IDSEL bit at all. The responder latency is varied between completions, which exercises the acknowledge hold-off. A strobe injected while a request is open tests that it is dropped.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_BUS  = 2'd2,
    SEL_NONE = 2'd3
  } lb_sel_e;

  localparam logic [WORD_W-1:0] ADDR_MASK = 32'h01FF_FF3F;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] regn;
  } cfg_tgt_t;

  function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [WORD_W-1:0] type0_addr(input cfg_tgt_t t, input int base);
    logic [WORD_W-1:0] a;
    a = '0;
    for (int i = 0; i < WORD_W; i++)
      if (i >= base && (i - base) == int'(t.dev)) a[i] = 1'b1;
    a[10:8] = t.fn;
    a[7:2]  = t.regn;
    return a;
  endfunction

  function automatic logic [WORD_W-1:0] type1_addr(input cfg_tgt_t t);
    return {8'h00, t.bus, t.dev, t.fn, t.regn, 2'b01};
  endfunction
endpackage

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
  import pci_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_bus,
  input  logic [WORD_W-1:0] wdata_loc,
  output logic [WORD_W-1:0] addr_img,
  output logic [7:0]        prim_bus,
  output cfg_tgt_t          tgt
);
  logic [WORD_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      prim_bus <= '0;
    end else begin
      if (wr_addr) addr_q <= bswap32(wdata_loc) & ADDR_MASK;
      if (wr_bus)  prim_bus <= wdata_loc[7:0];
    end
  end

  assign addr_img = addr_q;
  assign tgt = '{en: addr_q[24], bus: addr_q[23:16], dev: addr_q[12:8],
                 fn: addr_q[15:13], regn: addr_q[5:0]};

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q & ~ADDR_MASK) == '0);
endmodule

// File: rtl/pci_cfg_seq.sv
module pci_cfg_seq
  import pci_cfg_pkg::*;
#(
  parameter int IDSEL_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lb_stb,
  input  logic              lb_we,
  input  logic [1:0]        lb_sel,
  input  logic [3:0]        lb_be,
  input  logic [WORD_W-1:0] lb_wdata,
  input  logic [WORD_W-1:0] addr_img,
  input  logic [7:0]        prim_bus,
  input  cfg_tgt_t          tgt,
  output logic              accept_ok,
  output logic [WORD_W-1:0] lb_rdata,
  output logic              lb_ack,
  output logic              lb_err,
  output logic              pm_req,
  output logic              pm_write,
  output logic              pm_type1,
  output logic [WORD_W-1:0] pm_addr,
  output logic [WORD_W-1:0] pm_wdata,
  input  logic              pm_done,
  input  logic              pm_abort,
  input  logic [WORD_W-1:0] pm_rdata
);
  logic accept, bad, launch, finish, remote;

  assign accept    = lb_stb && !pm_req;
  assign bad       = (lb_be != 4'hF) || (lb_sel == SEL_NONE);
  assign accept_ok = accept && !bad;
  assign launch    = accept_ok && (lb_sel == SEL_DATA) && tgt.en;
  assign finish    = pm_req && pm_done;
  assign remote    = (tgt.bus != prim_bus);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lb_ack   <= 1'b0;
      lb_err   <= 1'b0;
      lb_rdata <= '0;
      pm_req   <= 1'b0;
      pm_write <= 1'b0;
      pm_type1 <= 1'b0;
      pm_addr  <= '0;
      pm_wdata <= '0;
    end else begin
      lb_ack <= 1'b0;
      lb_err <= 1'b0;
      if (finish) begin
        pm_req   <= 1'b0;
        lb_ack   <= 1'b1;
        lb_rdata <= pm_write ? '0 : (pm_abort ? '1 : bswap32(pm_rdata));
      end else if (accept) begin
        if (bad) begin
          lb_ack   <= 1'b1;
          lb_err   <= 1'b1;
          lb_rdata <= '0;
        end else if (launch) begin
          pm_req   <= 1'b1;
          pm_write <= lb_we;
          pm_type1 <= remote;
          pm_addr  <= remote ? type1_addr(tgt) : type0_addr(tgt, IDSEL_BASE);
          pm_wdata <= lb_we ? bswap32(lb_wdata) : '0;
        end else begin
          lb_ack <= 1'b1;
          if (lb_we) lb_rdata <= '0;
          else begin
            case (lb_sel)
              SEL_ADDR: lb_rdata <= bswap32(addr_img);
              SEL_BUS:  lb_rdata <= {24'h0, prim_bus};
              default:  lb_rdata <= '1;
            endcase
          end
        end
      end
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req && !pm_done |=> pm_req && $stable(pm_addr) && $stable(pm_write));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req && pm_done |=> !pm_req && lb_ack);
  a_r6_type1_tag: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req && pm_type1 |-> pm_addr[1:0] == 2'b01);
  a_r5_idsel: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req && !pm_type1 |-> pm_addr[1:0] == 2'b00 && $onehot0(pm_addr[WORD_W-1:IDSEL_BASE]));
  a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
    lb_stb && !pm_req && lb_be != 4'hF |=> lb_ack && lb_err && !pm_req);
  a_r8_local: assert property (@(posedge clk) disable iff (!rst_n)
    lb_stb && !pm_req && lb_sel == SEL_DATA && lb_be == 4'hF && !tgt.en |=> lb_ack && !pm_req);
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req && pm_done && pm_abort && !pm_write |=> lb_rdata == '1);
endmodule

// File: rtl/pci_cfg_host.sv
module pci_cfg_host
  import pci_cfg_pkg::*;
#(
  parameter int IDSEL_BASE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lb_stb,
  input  logic        lb_we,
  input  logic [1:0]  lb_sel,
  input  logic [3:0]  lb_be,
  input  logic [31:0] lb_wdata,
  output logic [31:0] lb_rdata,
  output logic        lb_ack,
  output logic        lb_err,
  output logic        pm_req,
  output logic        pm_write,
  output logic        pm_type1,
  output logic [31:0] pm_addr,
  output logic [31:0] pm_wdata,
  input  logic        pm_done,
  input  logic        pm_abort,
  input  logic [31:0] pm_rdata
);
  logic              accept_ok, wr_addr, wr_bus;
  logic [WORD_W-1:0] addr_img;
  logic [7:0]        prim_bus;
  cfg_tgt_t          tgt;

  assign wr_addr = accept_ok && lb_we && (lb_sel == SEL_ADDR);
  assign wr_bus  = accept_ok && lb_we && (lb_sel == SEL_BUS);

  pci_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_bus(wr_bus),
    .wdata_loc(lb_wdata), .addr_img(addr_img), .prim_bus(prim_bus), .tgt(tgt)
  );

  pci_cfg_seq #(.IDSEL_BASE(IDSEL_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .lb_stb(lb_stb), .lb_we(lb_we), .lb_sel(lb_sel),
    .lb_be(lb_be), .lb_wdata(lb_wdata), .addr_img(addr_img), .prim_bus(prim_bus),
    .tgt(tgt), .accept_ok(accept_ok), .lb_rdata(lb_rdata), .lb_ack(lb_ack),
    .lb_err(lb_err), .pm_req(pm_req), .pm_write(pm_write), .pm_type1(pm_type1),
    .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_done(pm_done),
    .pm_abort(pm_abort), .pm_rdata(pm_rdata)
  );
endmodule

// File: tb/pci_cfg_host_bench.sv
module pci_cfg_host_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, lb_stb = 1'b0, lb_we = 1'b0;
  logic [1:0]  lb_sel = 2'd0;
  logic [3:0]  lb_be = 4'hF;
  logic [31:0] lb_wdata = '0, lb_rdata, pm_addr, pm_wdata;
  logic        lb_ack, lb_err, pm_req, pm_write, pm_type1;
  logic        pm_done = 1'b0, pm_abort = 1'b0;
  logic [31:0] pm_rdata = '0;

  pci_cfg_host u_pci_cfg_host (
    .clk(clk), .rst_n(rst_n), .lb_stb(lb_stb), .lb_we(lb_we), .lb_sel(lb_sel),
    .lb_be(lb_be), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_ack(lb_ack),
    .lb_err(lb_err), .pm_req(pm_req), .pm_write(pm_write), .pm_type1(pm_type1),
    .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_done(pm_done),
    .pm_abort(pm_abort), .pm_rdata(pm_rdata)
  );

  int n_tests = 0, n_fail = 0;
  int lat = 1, cnt = 0, n_req = 0;
  bit exp_busy = 1'b0;
  logic [31:0] cap_addr, cap_wdata;
  logic cap_t1, cap_w;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = d[8*(3-i) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] tword(input int en, input int bus, input int dev,
                                        input int fn, input int rg);
    return 32'(en * 2**24 + bus * 2**16 + fn * 8192 + dev * 256 + rg);
  endfunction

  // PCI responder plus per-clock model comparison of pm_req
  always @(negedge clk) begin
    if (rst_n && pm_req && !exp_busy) begin
      n_tests++; n_fail++;
      $display("FAIL R8 unexpected pm_req actual=1 expected=0");
    end
    if (pm_done) pm_done = 1'b0;
    else if (pm_req) begin
      if (cnt >= lat) begin
        pm_done = 1'b1; cnt = 0; n_req++;
        cap_addr = pm_addr; cap_wdata = pm_wdata; cap_t1 = pm_type1; cap_w = pm_write;
      end else cnt++;
    end
  end

  task automatic access(input logic [1:0] sel, input bit we, input logic [3:0] be,
                        input logic [31:0] wd, input bit poke,
                        output logic [31:0] rd, output bit err, output int cyc);
    @(negedge clk);
    lb_stb = 1'b1; lb_sel = sel; lb_we = we; lb_be = be; lb_wdata = wd;
    @(negedge clk);
    lb_stb = 1'b0; cyc = 1;
    if (poke && !lb_ack) begin
      lb_stb = 1'b1; lb_we = 1'b0;
      @(negedge clk);
      lb_stb = 1'b0; cyc++;
    end
    while (!lb_ack && cyc < 40) begin @(negedge clk); cyc++; end
    rd = lb_rdata; err = lb_err;
  endtask

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd, w;
    bit err;
    int cyc, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    access(2'd0, 0, 4'hF, 0, 0, rd, err, cyc); chk("R1 addr port reset", rd, 0);
    access(2'd2, 0, 4'hF, 0, 0, rd, err, cyc); chk("R1 bus reg reset", rd, 0);

    access(2'd0, 1, 4'hF, 32'hFFFF_FFFF, 0, rd, err, cyc);
    access(2'd0, 0, 4'hF, 0, 0, rd, err, cyc); chk("R2 masked readback", rd, rev(32'h01FF_FF3F));
    w = rev(tword(0, 8'hA5, 7, 3, 6'h2A));
    access(2'd0, 1, 4'hF, w, 0, rd, err, cyc);
    access(2'd0, 0, 4'hF, 0, 0, rd, err, cyc); chk("R2 field readback", rd, w);

    access(2'd2, 1, 4'hF, 32'hFFFF_FF05, 0, rd, err, cyc);
    access(2'd2, 0, 4'hF, 0, 0, rd, err, cyc); chk("R3 bus number", rd, 32'h5);

    access(2'd0, 1, 4'h3, 32'h1234_5678, 0, rd, err, cyc); chk("R4 partial err", 32'(err), 1);
    access(2'd0, 0, 4'hF, 0, 0, rd, err, cyc); chk("R4 addr unchanged", rd, w);
    access(2'd3, 0, 4'hF, 0, 0, rd, err, cyc); chk("R4 sel3 err", 32'(err), 1);

    r0 = n_req;
    access(2'd1, 0, 4'hF, 0, 0, rd, err, cyc);
    chk("R8 disabled read ones", rd, 32'hFFFF_FFFF);
    chk("R8 disabled latency", 32'(cyc), 1);
    chk("R8 no request", 32'(n_req), 32'(r0));

    // type 0 write, device 3
    access(2'd0, 1, 4'hF, rev(tword(1, 5, 3, 2, 6'h11)), 0, rd, err, cyc);
    exp_busy = 1'b1; lat = 2;
    access(2'd1, 1, 4'hF, 32'h1122_3344, 0, rd, err, cyc);
    exp_busy = 1'b0;
    chk("R5 type0 tag", 32'(cap_t1), 0);
    chk("R5 type0 addr", cap_addr, 32'(2**19 + 2*256 + 17*4));
    chk("R7 write swap", cap_wdata, 32'h4433_2211);
    chk("R7 write flag", 32'(cap_w), 1);
    chk("R9 ack latency", 32'(cyc), 4);

    access(2'd1, 1, 4'h1, 32'h0, 0, rd, err, cyc); chk("R4 data partial err", 32'(err), 1);

    pm_rdata = 32'hA1B2_C3D4; exp_busy = 1'b1; lat = 0;
    access(2'd1, 0, 4'hF, 0, 0, rd, err, cyc);
    exp_busy = 1'b0;
    chk("R7 read swap", rd, 32'hD4C3_B2A1);
    chk("R9 ack latency lat0", 32'(cyc), 2);

    access(2'd0, 1, 4'hF, rev(tword(1, 5, 20, 7, 6'h3F)), 0, rd, err, cyc);
    exp_busy = 1'b1; lat = 1;
    access(2'd1, 0, 4'hF, 0, 0, rd, err, cyc);
    exp_busy = 1'b0;
    chk("R5 dev20 no idsel", cap_addr, 32'(7*256 + 63*4));

    access(2'd0, 1, 4'hF, rev(tword(1, 9, 31, 5, 6'h04)), 0, rd, err, cyc);
    exp_busy = 1'b1; lat = 3; r0 = n_req;
    access(2'd1, 0, 4'hF, 0, 1, rd, err, cyc);
    exp_busy = 1'b0;
    chk("R6 type1 tag", 32'(cap_t1), 1);
    chk("R6 type1 addr", cap_addr, 32'(9*65536 + 31*2048 + 5*256 + 4*4 + 1));
    chk("R9 poke ignored", 32'(n_req - r0), 1);
    @(negedge clk); @(negedge clk);
    chk("R9 no second req", 32'(pm_req), 0);

    pm_abort = 1'b1; exp_busy = 1'b1; lat = 1;
    access(2'd1, 0, 4'hF, 0, 0, rd, err, cyc);
    chk("R10 abort read ones", rd, 32'hFFFF_FFFF);
    access(2'd1, 1, 4'hF, 32'h5555_AAAA, 0, rd, err, cyc);
    exp_busy = 1'b0; pm_abort = 1'b0;
    chk("R10 abort write no err", 32'(err), 0);
    chk("R10 abort write acked", 32'(lb_ack), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule